// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block is a watchdog counter for a small microcontroller core. It counts ticks from one of two sources. The first source is a dedicated low-speed oscillator tick. The second is the instruction-clock tick, which stops while the core is halted. A power-of-two prescaler sits in front of the counter. Software programs the prescaler ratio through a control register, and keeps the watchdog from expiring by issuing clear strobes.

A configuration input picks one of two clearing schemes. In the first, any single strobe clears the timer. In the second, two distinct strobes must both arrive, in either order, before the timer clears. When the counter wraps, the block sets a time-out flag and raises a one-cycle reset request. The request is a full-reset request if the core was running, and a warm-reset request if it was halted. A warm reset only zeroes the program counter and the stack pointer.

The external reset, a software clear and entry into halt all clear the counter and the prescaler together.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is deasserted, `full_rst_req`, `warm_rst_req` and `to_flag` are 0, and `ctrl_q` reads 0.
- R2: Control bits 2:0 hold the ratio select N. After a clear, the request appears after exactly 2^(CNT_W+N) selected ticks. It is visible on the clock edge that follows the cycle carrying the last tick.
- R3: When `dual_clr` is 0, a strobe on either `clr_a` or `clr_b` clears both the counter and the prescaler.
- R4: When `dual_clr` is 1, the timer clears only once both `clr_a` and `clr_b` have been seen. They may come in either order or in the same cycle. Repeating one strobe has no effect, and both seen marks are dropped when the clear happens.
- R5: An overflow while `halted` is 0 produces a one-cycle `full_rst_req` pulse and sets `to_flag`.
- R6: An overflow while `halted` is 1 produces a one-cycle `warm_rst_req` pulse and sets `to_flag`.
- R7: A `halt_enter` strobe clears the counter, the prescaler and `to_flag`.
- R8: With `src_sel` = 0 (instruction-clock tick), no ticks are counted while `halted` is 1. Counting resumes from the held value once `halted` returns to 0.
- R9: Control bits 7:3 are flag bits that read back unchanged on `ctrl_q` and have no effect on the time-out period.
- R10: Writing a new ratio select does not clear the counter. The new ratio applies from the next prescaler boundary.
- R11: `full_rst_req` and `warm_rst_req` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| lf_tick | input | 1 | Tick from the low-speed oscillator |
| ic_tick | input | 1 | Tick from the instruction clock |
| src_sel | input | 1 | Tick source: 1 low-speed oscillator, 0 instruction clock |
| halted | input | 1 | Core is in halt mode |
| halt_enter | input | 1 | Strobe on entry into halt |
| dual_clr | input | 1 | 1 selects two-strobe clearing |
| clr_a | input | 1 | First clear strobe |
| clr_b | input | 1 | Second clear strobe |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | CTRL_W | Control write data (bits 2:0 ratio select) |
| ctrl_q | output | CTRL_W | Control register contents |
| to_flag | output | 1 | Time-out flag |
| full_rst_req | output | 1 | One-cycle full-reset request |
| warm_rst_req | output | 1 | One-cycle warm-reset request |

## Verification
The bench sweeps every ratio select and counts the ticks up to the request. This catches an off-by-one prescaler tap, which would move every period by a factor of two or by a single tick. In two-strobe mode it repeats one strobe, splits the pair across cycles in both orders, and fires both at once. A design that cleared on a lone strobe, or kept a stale seen mark, would time out at the wrong tick. Overflows are provoked both halted and running, to catch swapped request kinds. The bench holds the instruction-clock source through a halt, which exposes a counter that keeps running or one that resets. A mid-count ratio change exposes a counter wrongly cleared by a control write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic {
      WD_SRC_INSTR  = 1'b0,
      WD_SRC_LOWOSC = 1'b1
   } wdog_src_e;

   // width of a free-running prescaler able to reach ratio 2^(2^sel_w - 1)
   function automatic int unsigned pre_width(input int unsigned sel_w);
      return (1 << sel_w) - 1;
   endfunction

endpackage

// File: rtl/wdog_clr_ctl.sv
module wdog_clr_ctl #(
   parameter bit DUAL_CLR_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dual_clr,
   input  logic clr_a,
   input  logic clr_b,
   output logic sw_clr
);

   generate
      if (DUAL_CLR_EN) begin : g_dual
         logic seen_a_q, seen_b_q;
         logic have_a, have_b, pair_done;

         assign have_a    = seen_a_q | clr_a;
         assign have_b    = seen_b_q | clr_b;
         assign pair_done = have_a & have_b;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_a_q <= 1'b0;
               seen_b_q <= 1'b0;
            end else if (!dual_clr || pair_done) begin
               seen_a_q <= 1'b0;
               seen_b_q <= 1'b0;
            end else begin
               seen_a_q <= have_a;
               seen_b_q <= have_b;
            end
         end

         assign sw_clr = dual_clr ? pair_done : (clr_a | clr_b);
      end else begin : g_single
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, dual_clr};
         assign sw_clr    = clr_a | clr_b;
      end
   endgenerate

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
   import wdog_pkg::*;
#(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             step
);

   localparam int unsigned PRE_W  = pre_width(SEL_W);
   localparam int unsigned N_TAPS = 1 << SEL_W;

   logic [PRE_W-1:0]  pre_q;
   logic [N_TAPS-1:0] tap;

   generate
      for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
         if (i == 0) begin : g_unity
            assign tap[i] = 1'b1;
         end else begin : g_div
            assign tap[i] = &pre_q[i-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (clr)    pre_q <= '0;
      else if (tick)   pre_q <= pre_q + 1'b1;
   end

   assign step = tick & tap[sel];

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic ovf
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (step)  cnt_q <= cnt_q + 1'b1;
   end

   assign ovf = step & (&cnt_q) & ~clr;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned CTRL_W      = 8,
   parameter bit          DUAL_CLR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lf_tick,
   input  logic              ic_tick,
   input  logic              src_sel,
   input  logic              halted,
   input  logic              halt_enter,
   input  logic              dual_clr,
   input  logic              clr_a,
   input  logic              clr_b,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              to_flag,
   output logic              full_rst_req,
   output logic              warm_rst_req
);

   generate
      if (CNT_W < 2)       begin : g_bad_cnt  $error("CNT_W must be at least 2");        end
      if (SEL_W < 1 || SEL_W > 4)
                           begin : g_bad_sel  $error("SEL_W must lie in 1..4");          end
      if (CTRL_W < SEL_W)  begin : g_bad_ctrl $error("CTRL_W must cover the select field"); end
   endgenerate

   logic       sw_clr, clr_all, tick, step, ovf;
   wdog_src_e  src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (ctrl_we)  ctrl_q <= ctrl_wdata;
   end

   assign src  = wdog_src_e'(src_sel);
   assign tick = (src == WD_SRC_LOWOSC) ? lf_tick : (ic_tick & ~halted);

   wdog_clr_ctl #(.DUAL_CLR_EN(DUAL_CLR_EN)) u_clr (
      .clk(clk), .rst_n(rst_n), .dual_clr(dual_clr),
      .clr_a(clr_a), .clr_b(clr_b), .sw_clr(sw_clr)
   );

   assign clr_all = sw_clr | halt_enter;

   wdog_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .tick(tick),
      .sel(ctrl_q[SEL_W-1:0]), .step(step)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .step(step), .ovf(ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_rst_req <= 1'b0;
         warm_rst_req <= 1'b0;
         to_flag      <= 1'b0;
      end else begin
         full_rst_req <= ovf & ~halted;
         warm_rst_req <= ovf & halted;
         if (halt_enter) to_flag <= 1'b0;
         else if (ovf)   to_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic src_sel,
   input logic halted,
   input logic halt_enter,
   input logic dual_clr,
   input logic clr_a,
   input logic clr_b,
   input logic to_flag,
   input logic full_rst_req,
   input logic warm_rst_req
);

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_rst_req && warm_rst_req)); // R11

   AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst_req |=> !full_rst_req); // R11

   AST_WARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |=> !warm_rst_req); // R11

   AST_FULL_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_rst_req) |-> $past(!halted)); // R5

   AST_WARM_WHEN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warm_rst_req) |-> $past(halted)); // R6

   AST_REQ_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
      (full_rst_req || warm_rst_req) |-> to_flag); // R5

   AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      halt_enter |=> (!to_flag && !full_rst_req && !warm_rst_req)); // R7

   AST_SINGLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (!dual_clr && (clr_a || clr_b)) |=> !(full_rst_req || warm_rst_req)); // R3

   AST_PAIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_clr && clr_a && clr_b) |=> !(full_rst_req || warm_rst_req)); // R4

   AST_IC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !src_sel) |=> !warm_rst_req); // R8

endmodule

bind wdog_timer wdog_timer_chk u_wdog_chk (
   .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .halted(halted),
   .halt_enter(halt_enter), .dual_clr(dual_clr), .clr_a(clr_a), .clr_b(clr_b),
   .to_flag(to_flag), .full_rst_req(full_rst_req), .warm_rst_req(warm_rst_req)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

   localparam int unsigned CNT_W  = 4;
   localparam int unsigned SEL_W  = 3;
   localparam int unsigned CTRL_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lf_tick = 1'b0, ic_tick = 1'b0, src_sel = 1'b1, halted = 1'b0;
   logic halt_enter = 1'b0, dual_clr = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
   logic ctrl_we = 1'b0;
   logic [CTRL_W-1:0] ctrl_wdata = '0;
   logic [CTRL_W-1:0] ctrl_q;
   logic to_flag, full_rst_req, warm_rst_req;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   wdog_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W), .CTRL_W(CTRL_W), .DUAL_CLR_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .ic_tick(ic_tick), .src_sel(src_sel),
      .halted(halted), .halt_enter(halt_enter), .dual_clr(dual_clr), .clr_a(clr_a),
      .clr_b(clr_b), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
      .to_flag(to_flag), .full_rst_req(full_rst_req), .warm_rst_req(warm_rst_req)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send_tick();
      @(negedge clk);
      lf_tick = src_sel;
      ic_tick = !src_sel;
      @(negedge clk);
      lf_tick = 1'b0;
      ic_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) send_tick();
   endtask

   task automatic strobe(input logic a, input logic b);
      @(negedge clk);
      clr_a = a;
      clr_b = b;
      @(negedge clk);
      clr_a = 1'b0;
      clr_b = 1'b0;
   endtask

   task automatic enter_halt();
      @(negedge clk);
      halt_enter = 1'b1;
      @(negedge clk);
      halt_enter = 1'b0;
   endtask

   task automatic write_ctrl(input logic [CTRL_W-1:0] v);
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   // ticks until a request shows; reports kind, then checks it lasted one cycle
   task automatic to_req(input int limit, output int n, output logic f, output logic w);
      n = 0; f = 1'b0; w = 1'b0;
      for (int i = 1; i <= limit; i++) begin
         send_tick();
         if (full_rst_req || warm_rst_req) begin
            n = i; f = full_rst_req; w = warm_rst_req;
            break;
         end
      end
      @(negedge clk);
      check(!full_rst_req && !warm_rst_req, "R11 pulse width", full_rst_req | warm_rst_req, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      int n;
      logic f, w;
      logic [CTRL_W-1:0] v;
      int exp;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!full_rst_req && !warm_rst_req, "R1 requests", full_rst_req | warm_rst_req, 0);
      check(!to_flag, "R1 to_flag", to_flag, 0);
      check(ctrl_q == 0, "R1 ctrl_q", ctrl_q, 0);

      // R2/R5/R9 sweep every ratio, with varying flag bits, running, low-speed source
      for (int s = 0; s < 8; s++) begin
         v = {5'((s * 7 + 3) & 31), 3'(s)};
         write_ctrl(v);
         check(ctrl_q == v, "R9 readback", ctrl_q, v);
         strobe(1'b1, 1'b0);
         exp = 1 << (CNT_W + s);
         to_req(exp + 4, n, f, w);
         check(n == exp, "R2 period (R9 flags)", n, exp);
         check(f && !w, "R5 full request kind", {f, w}, 2);
         check(to_flag, "R5 to_flag", to_flag, 1);
      end

      // R3 single-strobe clear with clr_b
      write_ctrl(8'h00);
      strobe(1'b1, 1'b0);
      ticks(10);
      strobe(1'b0, 1'b1);
      to_req(40, n, f, w);
      check(n == 16, "R3 clr_b clears", n, 16);
      ticks(9);
      strobe(1'b1, 1'b0);
      to_req(40, n, f, w);
      check(n == 16, "R3 clr_a clears", n, 16);

      // R4 two-strobe clearing
      dual_clr = 1'b1;
      ticks(10);
      strobe(1'b1, 1'b0);
      strobe(1'b1, 1'b0);
      to_req(40, n, f, w);
      check(n == 6, "R4 repeated clr_a does not clear", n, 6);
      ticks(10);
      strobe(1'b1, 1'b0);
      ticks(3);
      strobe(1'b0, 1'b1);
      to_req(40, n, f, w);
      check(n == 16, "R4 a then b clears", n, 16);
      ticks(5);
      strobe(1'b0, 1'b1);
      ticks(2);
      strobe(1'b1, 1'b0);
      to_req(40, n, f, w);
      check(n == 16, "R4 b then a clears", n, 16);
      ticks(4);
      strobe(1'b0, 1'b1);
      to_req(40, n, f, w);
      check(n == 12, "R4 seen marks dropped after clear", n, 12);
      ticks(7);
      strobe(1'b1, 1'b1);
      to_req(40, n, f, w);
      check(n == 16, "R4 same-cycle pair clears", n, 16);
      dual_clr = 1'b0;

      // R6/R7 halted on low-speed source
      halted = 1'b1;
      enter_halt();
      check(!to_flag, "R7 halt entry clears to_flag", to_flag, 0);
      to_req(40, n, f, w);
      check(n == 16, "R6 halted period", n, 16);
      check(w && !f, "R6 warm request kind", {f, w}, 1);
      check(to_flag, "R6 to_flag", to_flag, 1);
      ticks(10);
      enter_halt();
      to_req(40, n, f, w);
      check(n == 16, "R7 halt entry clears counter", n, 16);
      halted = 1'b0;

      // R8 instruction-clock source frozen while halted
      src_sel = 1'b0;
      strobe(1'b1, 1'b0);
      ticks(6);
      halted = 1'b1;
      to_req(50, n, f, w);
      check(n == 0, "R8 no counting while halted", n, 0);
      halted = 1'b0;
      to_req(40, n, f, w);
      check(n == 10, "R8 resumes from held count", n, 10);
      src_sel = 1'b1;

      // R10 ratio change keeps the count
      strobe(1'b1, 1'b0);
      ticks(8);
      write_ctrl(8'h01);
      to_req(60, n, f, w);
      check(n == 16, "R10 ratio change does not clear", n, 16);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule